// File: doc/BRIEF.md
# Link Training Coefficient Requester

This block is the local request side of backplane link training. It owns the coefficient-update word sent toward the link partner and reads back the partner's per-tap status fields. A bin measurement unit outside the block supplies one early/late decision for each of two equalizer bins. These are the long-tail bin and the pre-cursor bin. From those decisions the block asks the partner to step its post-cursor tap c(+1) and its pre-cursor tap c(-1) up or down.

The block sends INITIALIZE once to bring the partner to its default taps. It returns every request to hold once the partner acknowledges it. It also notices when a tap keeps running into a range limit. The long-tail bin is settled first and the pre-cursor bin after it. When both bins have stopped, the block declares transmit training complete and raises its receiver-ready indication.

The control is a three-state machine:
- `FS_EVAL` examines partner status, retires acknowledged requests, issues INITIALIZE and counts limit hits.
  - It repeats while the update word keeps changing (transition EVAL→EVAL).
  - It moves to `FS_DECIDE` once the word is stable (EVAL→DECIDE).
  - It moves to `FS_DONE` when both bins are stopped (EVAL→DONE).
- `FS_DECIDE` waits for a bin decision and consumes exactly one (DECIDE→EVAL).
- `FS_DONE` holds until restart (restart→EVAL from any state).

Top module: `kr_lt_coef_requester`

## Requirements
- R1: The update word carries INITIALIZE at bit 12, the c(+1) request at bits 5:4 and the c(-1) request at bits 1:0. A request code is 0 for hold, 1 for increment and 2 for decrement. The c(0) request bits 3:2 and every other bit stay 0, and code 3 never appears.
- R2: The partner status input holds the c(+1) status at bits 5:4, the c(0) status at bits 3:2 and the c(-1) status at bits 1:0. Each field uses 0 = not updated, 1 = updated, 2 = at minimum, 3 = at maximum.
- R3: INITIALIZE is raised exactly once after reset or restart. It is raised only in an evaluation cycle in which all six partner status bits are 0 and no request is pending. With a quiet partner, the word reads 0x1000 after the first clock edge following reset.
- R4: A pending INITIALIZE is cleared only when none of the three partner status fields reads not updated.
- R5: In an evaluation cycle, a tap request whose status field is no longer not updated returns to hold.
- R6: When a decrement is answered with minimum, or an increment with maximum, that bin's limit counter advances. The third such hit stops the bin (LIMIT_HITS = 3).
- R7: New tap requests are issued only in the decision state, only when bin_valid is high, only while no INITIALIZE is pending, and only for a tap whose status is not updated and whose request is at hold. bin_req is high exactly while the block waits in the decision state, and the word is unchanged while bin_valid stays low.
- R8: While the long-tail bin is active, c(+1) is requested to increment if the long-tail bin is early and to decrement otherwise. c(-1) is requested to decrement whenever the pre-cursor bin is not early. Only after the long-tail bin has stopped is c(-1) stepped in either direction; any c(-1) increment therefore follows the last c(+1) request.
- R9: The long-tail bin stops when its previous decision was early and the current one is late. The pre-cursor bin stops when its previous decision was late and the current one is early. After reset or restart the previous decisions are late for long-tail and early for pre-cursor.
- R10: Once both bins have stopped, rx_ready goes high. It stays high with the update word frozen at 0 until restart.
- R11: A change to the update word in an evaluation cycle is followed by another evaluation cycle before any bin decision is consumed.
- R12: A synchronous restart clears every request, limit counter and stop flag and restores the previous-decision flags. After that edge the word is 0 and rx_ready and bin_req are low. INITIALIZE is then sent again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| restart | input | 1 | Synchronous restart of the training sequence |
| peer_stat | input | 6 | Partner status fields for c(+1), c(0), c(-1) |
| bin_valid | input | 1 | A fresh bin decision is present |
| long_early | input | 1 | Long-tail bin reads early |
| pre_early | input | 1 | Pre-cursor bin reads early |
| coef_upd | output | 16 | Coefficient-update word toward the partner |
| bin_req | output | 1 | Waiting for a bin decision |
| rx_ready | output | 1 | Transmit training complete, receiver ready |

## Verification
On every cycle, the assertions check several local rules:
- Requests never carry an illegal code.
- A request only falls back to hold after the partner answered.
- INITIALIZE only rises against a silent partner.
- No tap request starts while INITIALIZE is pending.
- The limit counters stay in range.
- Completion is sticky, with the word frozen.
- Restart empties the word.

Whether the bins stop at the right tap values can only be shown by the bench's scenarios. The same holds for the long-tail tap finishing before the pre-cursor tap is raised, and for the limit path stopping a tap at the edge of its range. The bench runs a modelled partner and sweeps both bin thresholds across and beyond the tap range.

// File: rtl/kr_lt_pkg.sv
package kr_lt_pkg;

    typedef enum logic [1:0] {
        REQ_HOLD = 2'd0,
        REQ_INC  = 2'd1,
        REQ_DEC  = 2'd2
    } req_e;

    typedef enum logic [1:0] {
        STS_NUPD = 2'd0,
        STS_UPD  = 2'd1,
        STS_MIN  = 2'd2,
        STS_MAX  = 2'd3
    } sts_e;

    typedef enum logic [1:0] {
        FS_EVAL,
        FS_DECIDE,
        FS_DONE
    } fsm_e;

    localparam int UPD_W    = 16;
    localparam int INIT_BIT = 12;
    localparam int CP1_LSB  = 4;
    localparam int CZ_LSB   = 2;
    localparam int CM1_LSB  = 0;
    localparam int STAT_W   = 6;
    localparam int BIN_LONG = 0;
    localparam int BIN_PRE  = 1;
    localparam int NUM_BINS = 2;

endpackage

// File: rtl/kr_lt_limit_cnt.sv
module kr_lt_limit_cnt #(
    parameter int LIMIT = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic hit,
    output logic reached
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (hit && !reached) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign reached = (cnt_q >= CW'(LIMIT));

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(LIMIT)); // R6

    AST_REACH_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (reached && !clr) |=> reached); // R6

endmodule

// File: rtl/kr_lt_req_fsm.sv
module kr_lt_req_fsm
    import kr_lt_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  restart,
    input  logic [STAT_W-1:0]     peer_stat,
    input  logic                  bin_valid,
    input  logic                  long_early,
    input  logic                  pre_early,
    input  logic [NUM_BINS-1:0]   lim_reached,
    output logic [NUM_BINS-1:0]   lim_hit,
    output logic [UPD_W-1:0]      coef_upd,
    output logic                  bin_req,
    output logic                  rx_ready
);
    fsm_e state_q, state_d;
    logic init_q, init_d;
    req_e rp1_q, rp1_d;
    req_e rm1_q, rm1_d;
    logic sent_q, sent_d;
    logic lstop_q, lstop_d;
    logic pstop_q, pstop_d;
    logic plong_q, plong_d;
    logic ppre_q, ppre_d;

    sts_e sp1, sz, sm1;
    logic lstop_eff, pstop_eff;
    logic changed;

    assign sp1 = sts_e'(peer_stat[CP1_LSB +: 2]);
    assign sz  = sts_e'(peer_stat[CZ_LSB  +: 2]);
    assign sm1 = sts_e'(peer_stat[CM1_LSB +: 2]);

    assign lstop_eff = lstop_q | lim_reached[BIN_LONG];
    assign pstop_eff = pstop_q | lim_reached[BIN_PRE];

    // next-state and next-request logic
    always_comb begin
        state_d = state_q;
        init_d  = init_q;
        rp1_d   = rp1_q;
        rm1_d   = rm1_q;
        sent_d  = sent_q;
        lstop_d = lstop_q;
        pstop_d = pstop_q;
        plong_d = plong_q;
        ppre_d  = ppre_q;
        lim_hit = '0;
        changed = 1'b0;

        unique case (state_q)
            FS_EVAL: begin
                if (lstop_eff && pstop_eff) begin
                    state_d = FS_DONE;
                end else begin
                    if (init_q && sp1 != STS_NUPD && sz != STS_NUPD && sm1 != STS_NUPD) begin
                        init_d = 1'b0;
                    end
                    if (!sent_q && peer_stat == '0 && !init_q &&
                        rp1_q == REQ_HOLD && rm1_q == REQ_HOLD) begin
                        init_d = 1'b1;
                        sent_d = 1'b1;
                    end
                    if (sp1 != STS_NUPD && rp1_q != REQ_HOLD) begin
                        rp1_d = REQ_HOLD;
                        if ((rp1_q == REQ_DEC && sp1 == STS_MIN) ||
                            (rp1_q == REQ_INC && sp1 == STS_MAX)) begin
                            lim_hit[BIN_LONG] = 1'b1;
                        end
                    end
                    if (sm1 != STS_NUPD && rm1_q != REQ_HOLD) begin
                        rm1_d = REQ_HOLD;
                        if ((rm1_q == REQ_DEC && sm1 == STS_MIN) ||
                            (rm1_q == REQ_INC && sm1 == STS_MAX)) begin
                            lim_hit[BIN_PRE] = 1'b1;
                        end
                    end
                    changed = (init_d != init_q) || (rp1_d != rp1_q) || (rm1_d != rm1_q);
                    state_d = changed ? FS_EVAL : FS_DECIDE;
                end
            end
            FS_DECIDE: begin
                if (bin_valid) begin
                    state_d = FS_EVAL;
                    if (!pstop_eff && !ppre_q && pre_early) begin
                        pstop_d = 1'b1;
                    end else if (!lstop_eff && plong_q && !long_early) begin
                        lstop_d = 1'b1;
                    end else if (!init_q) begin
                        if (!lstop_eff) begin
                            if (sm1 == STS_NUPD && rm1_q == REQ_HOLD && !pre_early) begin
                                rm1_d  = REQ_DEC;
                                ppre_d = 1'b0;
                            end
                            if (sp1 == STS_NUPD && rp1_q == REQ_HOLD) begin
                                rp1_d   = long_early ? REQ_INC : REQ_DEC;
                                plong_d = long_early;
                            end
                        end else if (!pstop_eff) begin
                            if (sm1 == STS_NUPD && rm1_q == REQ_HOLD) begin
                                rm1_d  = pre_early ? REQ_INC : REQ_DEC;
                                ppre_d = pre_early;
                            end
                        end
                    end
                end
            end
            FS_DONE: begin
                state_d = FS_DONE;
            end
            default: begin
                state_d = FS_EVAL;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FS_EVAL;
            init_q  <= 1'b0;
            rp1_q   <= REQ_HOLD;
            rm1_q   <= REQ_HOLD;
            sent_q  <= 1'b0;
            lstop_q <= 1'b0;
            pstop_q <= 1'b0;
            plong_q <= 1'b0;
            ppre_q  <= 1'b1;
        end else if (restart) begin
            state_q <= FS_EVAL;
            init_q  <= 1'b0;
            rp1_q   <= REQ_HOLD;
            rm1_q   <= REQ_HOLD;
            sent_q  <= 1'b0;
            lstop_q <= 1'b0;
            pstop_q <= 1'b0;
            plong_q <= 1'b0;
            ppre_q  <= 1'b1;
        end else begin
            state_q <= state_d;
            init_q  <= init_d;
            rp1_q   <= rp1_d;
            rm1_q   <= rm1_d;
            sent_q  <= sent_d;
            lstop_q <= lstop_d;
            pstop_q <= pstop_d;
            plong_q <= plong_d;
            ppre_q  <= ppre_d;
        end
    end

    // outputs
    always_comb begin
        coef_upd                   = '0;
        coef_upd[INIT_BIT]         = init_q;
        coef_upd[CP1_LSB +: 2]     = rp1_q;
        coef_upd[CM1_LSB +: 2]     = rm1_q;
        bin_req                    = (state_q == FS_DECIDE);
        rx_ready                   = (state_q == FS_DONE);
    end

    AST_LEGAL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        coef_upd[CP1_LSB +: 2] != 2'd3 && coef_upd[CM1_LSB +: 2] != 2'd3 &&
        coef_upd[CZ_LSB +: 2] == 2'd0); // R1

    AST_INIT_QUIET_PEER: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(coef_upd[INIT_BIT]) |-> $past(peer_stat == '0)); // R3

    AST_INIT_CLEAR_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(coef_upd[INIT_BIT]) |->
            ($past(restart) || ($past(sp1) != STS_NUPD && $past(sz) != STS_NUPD &&
                                $past(sm1) != STS_NUPD))); // R4

    AST_P1_HOLD_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(coef_upd[CP1_LSB +: 2] != 2'd0) |->
            ($past(restart) || $past(sp1) != STS_NUPD)); // R5

    AST_M1_HOLD_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(coef_upd[CM1_LSB +: 2] != 2'd0) |->
            ($past(restart) || $past(sm1) != STS_NUPD)); // R5

    AST_NO_REQ_UNDER_INIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|{coef_upd[CP1_LSB +: 2], coef_upd[CM1_LSB +: 2]}) |->
            ($past(!coef_upd[INIT_BIT]) && $past(bin_valid) && $past(bin_req))); // R7

    AST_READY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ready && !restart) |=> (rx_ready && $stable(coef_upd))); // R10

    AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (coef_upd == '0 && !rx_ready && !bin_req)); // R12

endmodule

// File: rtl/kr_lt_coef_requester.sv
module kr_lt_coef_requester
    import kr_lt_pkg::*;
#(
    parameter int LIMIT_HITS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic [5:0]        peer_stat,
    input  logic              bin_valid,
    input  logic              long_early,
    input  logic              pre_early,
    output logic [15:0]       coef_upd,
    output logic              bin_req,
    output logic              rx_ready
);
    logic [NUM_BINS-1:0] lim_hit;
    logic [NUM_BINS-1:0] lim_reached;

    kr_lt_req_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .restart     (restart),
        .peer_stat   (peer_stat),
        .bin_valid   (bin_valid),
        .long_early  (long_early),
        .pre_early   (pre_early),
        .lim_reached (lim_reached),
        .lim_hit     (lim_hit),
        .coef_upd    (coef_upd),
        .bin_req     (bin_req),
        .rx_ready    (rx_ready)
    );

    for (genvar b = 0; b < NUM_BINS; b++) begin : g_lim
        kr_lt_limit_cnt #(
            .LIMIT (LIMIT_HITS)
        ) u_cnt (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (restart),
            .hit     (lim_hit[b]),
            .reached (lim_reached[b])
        );
    end

endmodule

// File: tb/kr_lt_coef_requester_tb_top.sv
module kr_lt_coef_requester_tb_top;
    localparam int CLK_P   = 10;
    localparam int TAP_MAX = 7;
    localparam int P1_INIT = 3;
    localparam int M1_INIT = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        restart = 1'b0;
    logic [5:0]  peer_stat = '0;
    logic        bin_valid = 1'b0;
    logic        long_early = 1'b0;
    logic        pre_early = 1'b0;
    logic [15:0] dut_upd;
    logic        bin_req;
    logic        rx_ready;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit auto_on = 0;
    int thr_l = 0;
    int thr_p = 0;
    int tap [3];
    logic [1:0] sts [3];
    int init_rises = 0;
    bit prev_init = 0;
    int bad_bits = 0;
    int last_p1 = -1;
    int first_inc = -1;

    always #(CLK_P/2) clk = ~clk;

    kr_lt_coef_requester #(.LIMIT_HITS(3)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (restart),
        .peer_stat  (peer_stat),
        .bin_valid  (bin_valid),
        .long_early (long_early),
        .pre_early  (pre_early),
        .coef_upd   (dut_upd),
        .bin_req    (bin_req),
        .rx_ready   (rx_ready)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
        end
    endtask

    // partner model: answers requests with the R2 status encoding
    task automatic partner();
        logic [1:0] rq [3];
        rq[0] = dut_upd[5:4];
        rq[1] = dut_upd[3:2];
        rq[2] = dut_upd[1:0];
        if (dut_upd[12]) begin
            if (sts[0] == 0 && sts[1] == 0 && sts[2] == 0) begin
                tap[0] = P1_INIT;
                tap[2] = M1_INIT;
                for (int t = 0; t < 3; t++) sts[t] = 2'd1;
            end
        end else begin
            for (int t = 0; t < 3; t++) begin
                if (rq[t] == 2'd0) begin
                    sts[t] = 2'd0;
                end else if (sts[t] == 2'd0) begin
                    if (rq[t] == 2'd1) begin
                        if (tap[t] == TAP_MAX) sts[t] = 2'd3;
                        else begin tap[t]++; sts[t] = 2'd1; end
                    end else begin
                        if (tap[t] == 0) sts[t] = 2'd2;
                        else begin tap[t]--; sts[t] = 2'd1; end
                    end
                end
            end
        end
        peer_stat  = {sts[0], sts[1], sts[2]};
        long_early = (tap[0] < thr_l);
        pre_early  = (tap[2] <= thr_p);
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        cyc++;
        if (auto_on) begin
            if (dut_upd[12] && !prev_init) init_rises++;
            prev_init = dut_upd[12];
            if ((dut_upd & ~16'h1033) != 0 || dut_upd[5:4] == 2'd3 || dut_upd[1:0] == 2'd3)
                bad_bits++;
            if (dut_upd[5:4] != 0) last_p1 = cyc;
            if (dut_upd[1:0] == 2'd1 && first_inc < 0) first_inc = cyc;
            partner();
        end
    endtask

    task automatic begin_case(input int tl, input int tp);
        thr_l = tl;
        thr_p = tp;
        for (int t = 0; t < 3; t++) begin tap[t] = 0; sts[t] = 2'd0; end
        peer_stat = '0;
        init_rises = 0;
        prev_init = 0;
        bad_bits = 0;
        last_p1 = -1;
        first_inc = -1;
        auto_on = 1;
        bin_valid = 1'b1;
        restart = 1'b1;
        step();
        restart = 1'b0;
    endtask

    task automatic finish_case(input int tl, input int tp);
        int exp_p1;
        int exp_m1;
        for (int k = 0; k < 3000 && !rx_ready; k++) step();
        exp_p1 = (tl > TAP_MAX) ? TAP_MAX : tl;
        exp_m1 = (tp > TAP_MAX) ? TAP_MAX : tp;
        chk(rx_ready == 1'b1, "R10 training completes", rx_ready, 1);
        if (tl == 0 || tl > TAP_MAX)
            chk(tap[0] == exp_p1, "R6 c(+1) stopped by limit", tap[0], exp_p1);
        else
            chk(tap[0] == exp_p1, "R9 c(+1) stop at long-tail crossing", tap[0], exp_p1);
        if (tp >= TAP_MAX)
            chk(tap[2] == exp_m1, "R6 c(-1) stopped by limit", tap[2], exp_m1);
        else
            chk(tap[2] == exp_m1, "R9 c(-1) stop at pre-cursor crossing", tap[2], exp_m1);
        chk(init_rises == 1, "R3 single INITIALIZE", init_rises, 1);
        chk(bad_bits == 0, "R1 word layout and codes", bad_bits, 0);
        if (first_inc >= 0)
            chk(first_inc > last_p1, "R8 c(-1) raise after long-tail done", first_inc, last_p1 + 1);
        chk(dut_upd == 16'h0, "R10 word idle at completion", dut_upd, 0);
        step();
        step();
        chk(rx_ready == 1'b1 && dut_upd == 16'h0, "R10 completion holds", {rx_ready, dut_upd}, 17'h10000);
    endtask

    initial begin
        #(CLK_P * 190000);
        bad++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int t = 0; t < 3; t++) begin tap[t] = 0; sts[t] = 2'd0; end
        repeat (3) @(negedge clk);
        chk(dut_upd == 16'h0 && !rx_ready && !bin_req, "R12 reset state", {rx_ready, bin_req, dut_upd}, 0);
        rst_n = 1'b1;

        // directed handshake with a manually driven partner
        step();
        chk(dut_upd == 16'h1000, "R3 INITIALIZE on quiet partner", dut_upd, 16'h1000);
        chk(bin_req == 1'b0, "R11 still evaluating", bin_req, 0);
        peer_stat = 6'b01_00_01;
        step();
        chk(dut_upd[12] == 1'b1, "R4 INITIALIZE kept while c(0) not updated", dut_upd, 16'h1000);
        bin_valid = 1'b1; long_early = 1'b0; pre_early = 1'b1;
        step();
        chk(dut_upd == 16'h1000, "R7 no tap request under INITIALIZE", dut_upd, 16'h1000);
        peer_stat = 6'b01_01_01;
        step();
        chk(dut_upd == 16'h0, "R4 INITIALIZE cleared when all answered", dut_upd, 0);
        chk(bin_req == 1'b0, "R11 re-evaluation after change", bin_req, 0);
        peer_stat = 6'b0;
        bin_valid = 1'b0;
        step();
        chk(bin_req == 1'b1 && dut_upd == 16'h0, "R3 R11 decision after stable word", {bin_req, dut_upd}, 17'h10000);
        for (int k = 0; k < 4; k++) begin
            step();
            chk(bin_req == 1'b1 && dut_upd == 16'h0, "R7 waits for bin_valid", {bin_req, dut_upd}, 17'h10000);
        end
        bin_valid = 1'b1; long_early = 1'b1; pre_early = 1'b0;
        step();
        chk(dut_upd == 16'h0012, "R8 c(+1) inc and c(-1) dec", dut_upd, 16'h0012);
        peer_stat = 6'b11_00_10;
        step();
        chk(dut_upd == 16'h0, "R5 requests back to hold on answer", dut_upd, 0);
        peer_stat = 6'b0;

        // mid-run restart
        begin_case(6, 1);
        for (int k = 0; k < 12; k++) step();
        restart = 1'b1;
        step();
        restart = 1'b0;
        chk(dut_upd == 16'h0 && !rx_ready && !bin_req, "R12 restart clears", {rx_ready, bin_req, dut_upd}, 0);
        init_rises = 0;
        prev_init = 0;
        step();
        chk(dut_upd[12] == 1'b1, "R12 INITIALIZE resent", dut_upd, 16'h1000);
        finish_case(6, 1);

        // threshold sweep across and beyond the tap range
        for (int tl = 0; tl <= TAP_MAX + 1; tl++) begin
            for (int tp = 0; tp <= TAP_MAX + 1; tp++) begin
                begin_case(tl, tp);
                finish_case(tl, tp);
            end
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule